// File: doc/BRIEF.md
# Parallel ADC Conversion Controller

This block drives a 16-bit successive-approximation converter that has a parallel result bus. It controls two active-low strobes on the converter: chip-select (`csN`) and a read/convert line (`rcN`, low means convert and high means read). It also watches the converter's BUSY flag, which is asynchronous and is high when the converter is idle. A conversion always starts by pulling `rcN` low first. After a programmed setup time, `csN` follows it low. When the conversion completes, the controller captures the result bus and shows it on `resultData` with a one-cycle `resultValid` strobe.

Conversions start in one of two ways: a single-cycle `startReq` pulse, or free-running mode at a programmable period. Successive starts are always spaced by at least one throughput interval. Once BUSY rises, the controller releases chip-select inside a fixed window, so a second conversion can never start without a full acquisition period. An idle controller can also re-read the held result from the converter with a deferred read cycle.

If BUSY never returns, a timeout raises a sticky error and both strobes are released. Start requests that arrive while the converter is occupied are held one deep, or flagged as an overrun. A parameter selects which.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, `csN` and `rcN` are high and `resultValid`, `timeoutErr` and `overrunErr` are low.
- R2: For a conversion, `rcN` goes low at least SETUP_CYC cycles before `csN` falls. `rcN` never falls while `csN` is low.
- R3: Each conversion whose BUSY rise is seen produces exactly one single-cycle `resultValid` pulse. `resultData` then equals the value on `dataIn` when BUSY rose.
- R4: `rcN` is high for the whole wait on BUSY, and `csN` returns high within HAZARD_CYC cycles of BUSY rising.
- R5: Two conversion starts (a fall of `csN` while `rcN` is low) are at least THRU_CYC cycles apart.
- R6: With QUEUE_START=1, a `startReq` that arrives during a conversion or the throughput interval is held and run as soon as the interval ends. It is neither lost nor flagged.
- R7: A `startReq` that cannot be held is dropped and sets the sticky `overrunErr`. This applies to a request that arrives while one is already held, or to any blocked request when QUEUE_START=0.
- R8: If BUSY does not rise within TIMEOUT_CYC cycles of `rcN` returning high, the sticky `timeoutErr` is set and both strobes return high.
- R9: A `readReq` pulse while idle holds `csN` low with `rcN` high for READ_CYC cycles. It then presents the bus value with one `resultValid` pulse and starts no conversion.
- R10: With `freeRun` high, conversion starts are spaced by max(`periodCycles`, THRU_CYC) plus at most SETUP_CYC+4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Single-cycle conversion request |
| freeRun | input | 1 | Start conversions periodically while high |
| periodCycles | input | PER_W | Free-running period in clock cycles |
| readReq | input | 1 | Single-cycle deferred-read request |
| csN | output | 1 | Converter chip-select, active low |
| rcN | output | 1 | Converter read/convert line, low = convert |
| busyIn | input | 1 | Converter BUSY flag, asynchronous, high = idle |
| dataIn | input | DATA_W | Converter result bus |
| resultData | output | DATA_W | Last captured result |
| resultValid | output | 1 | One-cycle strobe for a new result |
| timeoutErr | output | 1 | Sticky: BUSY did not return in time |
| overrunErr | output | 1 | Sticky: a start request was dropped |

## Verification
The bench models the converter. It records every strobe edge, so it catches any start where chip-select leads read/convert (the noisy ordering) or where the setup gap is short. It measures the delay from BUSY rising to chip-select releasing, which a controller that lingered would blow past, letting a second conversion start without acquisition. Back-to-back, queued and free-running starts are timed against the throughput floor, which a design that restarted on the raw request would violate. A hung converter must leave the strobes high with the error set, and a deferred read must return the held value without starting a conversion.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_CAPT,
    ST_READ
  } ctrlState_t;

  typedef struct packed {
    logic capture;
    logic startMark;
  } ctrlStrobe_t;

endpackage

// File: rtl/adc_ctrl_datapath.sv
module adc_ctrl_datapath
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int THRU_CYC    = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [PER_W-1:0]  periodCycles,
  input  ctrlStrobe_t       strb,
  output logic              busyRise,
  output logic              thruOk,
  output logic              periodDue,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid
);

  localparam logic [PER_W-1:0] THRU_LIM = PER_W'(THRU_CYC);
  localparam logic [PER_W-1:0] CNT_MAX  = {PER_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   busyPrev;
  logic [PER_W-1:0]       sinceStart;

  // BUSY is asynchronous: shift it through a synchronizer chain first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= {SYNC_STAGES{1'b1}};
      busyPrev <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], busyIn};
      busyPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign busyRise = syncQ[SYNC_STAGES-1] & ~busyPrev;

  // cycles since the last conversion start, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceStart <= CNT_MAX;
    else if (strb.startMark)    sinceStart <= '0;
    else if (sinceStart != CNT_MAX) sinceStart <= sinceStart + 1'b1;
  end

  assign thruOk    = (sinceStart >= THRU_LIM);
  assign periodDue = (sinceStart >= periodCycles);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.capture;
      if (strb.capture) resultData <= dataIn;
    end
  end

  // R3: a result strobe never lasts two cycles
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R5: the control only starts when the throughput interval has passed
  assert_thru_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.startMark |-> thruOk);

endmodule

// File: rtl/adc_ctrl_fsm.sv
module adc_ctrl_fsm
  import adc_ctrl_pkg::*;
#(
  parameter int SETUP_CYC   = 3,
  parameter int STROBE_CYC  = 5,
  parameter int TIMEOUT_CYC = 600,
  parameter int READ_CYC    = 9,
  parameter int HAZARD_CYC  = 25,
  parameter bit QUEUE_START = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        freeRun,
  input  logic        readReq,
  input  logic        busyRise,
  input  logic        thruOk,
  input  logic        periodDue,
  output ctrlStrobe_t strb,
  output logic        csN,
  output logic        rcN,
  output logic        timeoutErr,
  output logic        overrunErr
);

  localparam int M1    = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int M2    = (M1 > READ_CYC) ? M1 : READ_CYC;
  localparam int MAXC  = (M2 > TIMEOUT_CYC) ? M2 : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int HZ_W  = $clog2(HAZARD_CYC + 2);

  localparam logic [CNT_W-1:0] SETUP_END   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_END  = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_END = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] READ_END    = CNT_W'(READ_CYC - 1);

  ctrlState_t       st, stNext;
  logic [CNT_W-1:0] phaseCnt;
  logic             pending;
  logic             goConv;
  logic             waitExpired;

  assign goConv      = (st == ST_IDLE) && thruOk &&
                       (pending || startReq || (freeRun && periodDue));
  assign waitExpired = (st == ST_WAIT) && !busyRise && (phaseCnt == TIMEOUT_END);

  always_comb begin
    stNext = st;
    strb   = '0;
    unique case (st)
      ST_IDLE: begin
        if (goConv)       stNext = ST_SETUP;
        else if (readReq) stNext = ST_READ;
      end
      ST_SETUP: begin
        if (phaseCnt == SETUP_END) begin
          stNext         = ST_STROBE;
          strb.startMark = 1'b1;
        end
      end
      ST_STROBE: if (phaseCnt == STROBE_END) stNext = ST_WAIT;
      ST_WAIT: begin
        if (busyRise)         stNext = ST_CAPT;
        else if (waitExpired) stNext = ST_IDLE;
      end
      ST_CAPT: begin
        strb.capture = 1'b1;
        stNext       = ST_IDLE;
      end
      ST_READ: begin
        if (phaseCnt == READ_END) begin
          strb.capture = 1'b1;
          stNext       = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      phaseCnt <= '0;
      csN      <= 1'b1;
      rcN      <= 1'b1;
    end else begin
      st       <= stNext;
      phaseCnt <= (stNext != st) ? '0 : phaseCnt + 1'b1;
      // strobes are registered from the next state so they never glitch
      csN <= !(stNext inside {ST_STROBE, ST_WAIT, ST_CAPT, ST_READ});
      rcN <= !(stNext inside {ST_SETUP, ST_STROBE});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending    <= 1'b0;
      overrunErr <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (waitExpired) timeoutErr <= 1'b1;
      if (goConv) begin
        if (startReq && pending) begin
          if (QUEUE_START) pending <= 1'b1;
          else             overrunErr <= 1'b1;
        end else begin
          pending <= 1'b0;
        end
      end else if (startReq) begin
        if (QUEUE_START && !pending) pending <= 1'b1;
        else                         overrunErr <= 1'b1;
      end
    end
  end

  // counter for the release window after BUSY rises (used by R4 check)
  logic            relArmed;
  logic [HZ_W-1:0] relCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relArmed <= 1'b0;
      relCnt   <= '0;
    end else if (busyRise) begin
      relArmed <= 1'b1;
      relCnt   <= '0;
    end else if (relArmed) begin
      if (csN) relArmed <= 1'b0;
      else if (relCnt != {HZ_W{1'b1}}) relCnt <= relCnt + 1'b1;
    end
  end

  // R2: read/convert may never fall while chip-select is low
  assert_rc_before_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rcN) |-> csN);

  // R2: both low only if read/convert was already low the cycle before
  assert_rc_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rcN) |-> $past(!rcN));

  // R4: chip-select released inside the hazard window
  assert_release_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    relArmed |-> (relCnt < HZ_W'(HAZARD_CYC)));

  // R7: overrun flag is sticky
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |=> overrunErr);

  // R8: timeout flag is sticky
  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> timeoutErr);

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 3,
  parameter int STROBE_CYC  = 5,
  parameter int THRU_CYC    = 400,
  parameter int TIMEOUT_CYC = 600,
  parameter int READ_CYC    = 9,
  parameter int HAZARD_CYC  = 25,
  parameter bit QUEUE_START = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              freeRun,
  input  logic [PER_W-1:0]  periodCycles,
  input  logic              readReq,
  output logic              csN,
  output logic              rcN,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid,
  output logic              timeoutErr,
  output logic              overrunErr
);

  ctrlStrobe_t strb;
  logic        busyRise, thruOk, periodDue;

  adc_ctrl_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .READ_CYC   (READ_CYC),
    .HAZARD_CYC (HAZARD_CYC),
    .QUEUE_START(QUEUE_START)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .readReq(readReq), .busyRise(busyRise), .thruOk(thruOk),
    .periodDue(periodDue), .strb(strb), .csN(csN), .rcN(rcN),
    .timeoutErr(timeoutErr), .overrunErr(overrunErr)
  );

  adc_ctrl_datapath #(
    .DATA_W     (DATA_W),
    .PER_W      (PER_W),
    .SYNC_STAGES(SYNC_STAGES),
    .THRU_CYC   (THRU_CYC)
  ) uData (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .dataIn(dataIn),
    .periodCycles(periodCycles), .strb(strb), .busyRise(busyRise),
    .thruOk(thruOk), .periodDue(periodDue), .resultData(resultData),
    .resultValid(resultValid)
  );

endmodule

// File: tb/sim_adc_conv_ctrl.sv
`timescale 1ns/1ps
module sim_adc_conv_ctrl;

  localparam int SETUP  = 3;
  localparam int THRU   = 400;
  localparam int TMO    = 600;
  localparam int READC  = 9;
  localparam int HAZARD = 25;
  localparam int CONV   = 330;

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 1'b0, freeRun = 1'b0, readReq = 1'b0;
  logic [15:0] periodCycles = 16'd0;
  logic csN, rcN, resultValid, timeoutErr, overrunErr;
  logic busyIn = 1'b1;
  logic [15:0] dataIn = 16'h0;
  logic [15:0] resultData;

  int checks = 0, fails = 0, cyc = 0;
  int convCount = 0, validCnt = 0, prevStart = -1, lastSpacing = 0;
  int rcFall = 0, riseCyc = 0;
  bit riseArmed = 0, hang = 0;
  logic [15:0] modelLast = 16'h0;

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  adc_conv_ctrl #(.SETUP_CYC(SETUP), .THRU_CYC(THRU), .TIMEOUT_CYC(TMO),
                  .READ_CYC(READC), .HAZARD_CYC(HAZARD)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .periodCycles(periodCycles), .readReq(readReq), .csN(csN), .rcN(rcN),
    .busyIn(busyIn), .dataIn(dataIn), .resultData(resultData),
    .resultValid(resultValid), .timeoutErr(timeoutErr), .overrunErr(overrunErr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model
  always @(negedge rcN) begin
    rcFall = cyc;
    chk(csN === 1'b1, "R2 rc fell with cs low", csN, 1);
  end

  always @(negedge csN) begin
    if (!rcN && !hang) begin
      chk(cyc - rcFall >= SETUP, "R2 setup gap", cyc - rcFall, SETUP);
      if (prevStart >= 0) begin
        lastSpacing = cyc - prevStart;
        chk(lastSpacing >= THRU, "R5 start spacing", lastSpacing, THRU);
      end
      prevStart = cyc;
      convCount++;
      busyIn = 1'b0;
      dataIn = 16'h0;
      repeat (CONV) @(posedge clk);
      dataIn = 16'h1234 ^ 16'(convCount * 16'h0F1D);
      modelLast = dataIn;
      repeat (3) @(posedge clk);
      busyIn = 1'b1;
      riseCyc = cyc;
      riseArmed = 1;
      chk(rcN === 1'b1, "R4 rc high during wait", rcN, 1);
    end
  end

  always @(posedge csN) begin
    if (riseArmed) begin
      riseArmed = 0;
      chk(cyc - riseCyc <= HAZARD, "R4 cs release", cyc - riseCyc, HAZARD);
    end
  end

  always @(negedge clk) begin
    if (rstN && resultValid) begin
      validCnt++;
      chk(resultData == modelLast, "R3 R9 result value", resultData, modelLast);
    end
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    waitCyc(3);
    chk(csN === 1'b1 && rcN === 1'b1, "R1 strobes idle", {csN, rcN}, 3);
    chk(resultValid === 1'b0 && timeoutErr === 1'b0 && overrunErr === 1'b0,
        "R1 flags clear", {resultValid, timeoutErr, overrunErr}, 0);
  endtask

  task automatic testSingle();
    int v0 = validCnt, c0 = convCount;
    pulseStart();
    waitCyc(450);
    chk(convCount == c0 + 1, "R3 one conversion", convCount - c0, 1);
    chk(validCnt == v0 + 1, "R3 one valid pulse", validCnt - v0, 1);
  endtask

  task automatic testQueued();
    int c0 = convCount, v0 = validCnt;
    pulseStart();
    waitCyc(60);
    pulseStart();
    waitCyc(1000);
    chk(convCount == c0 + 2, "R6 held request runs", convCount - c0, 2);
    chk(validCnt == v0 + 2, "R6 two results", validCnt - v0, 2);
    chk(overrunErr === 1'b0, "R6 no overrun", overrunErr, 0);
  endtask

  task automatic testOverrun();
    int c0 = convCount;
    pulseStart();
    waitCyc(30);
    pulseStart();
    waitCyc(30);
    pulseStart();
    waitCyc(1000);
    chk(convCount == c0 + 2, "R7 extra request dropped", convCount - c0, 2);
    chk(overrunErr === 1'b1, "R7 overrun flag", overrunErr, 1);
  endtask

  task automatic testRead();
    int c0 = convCount, v0 = validCnt;
    @(negedge clk) readReq = 1'b1;
    @(negedge clk) readReq = 1'b0;
    waitCyc(3);
    chk(csN === 1'b0 && rcN === 1'b1, "R9 read strobes", {csN, rcN}, 1);
    waitCyc(30);
    chk(validCnt == v0 + 1, "R9 read result", validCnt - v0, 1);
    chk(convCount == c0, "R9 no conversion", convCount - c0, 0);
  endtask

  task automatic testFreeRun(input int period);
    int c0 = convCount, lim = 0, gap = (period > THRU) ? period : THRU;
    periodCycles = 16'(period);
    @(negedge clk) freeRun = 1'b1;
    while (convCount < c0 + 3 && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    freeRun = 1'b0;
    chk(lastSpacing >= gap && lastSpacing <= gap + SETUP + 4,
        "R10 free-run spacing", lastSpacing, gap);
    waitCyc(500);
  endtask

  task automatic testTimeout();
    int v0 = validCnt;
    hang = 1;
    pulseStart();
    waitCyc(TMO + 60);
    chk(timeoutErr === 1'b1, "R8 timeout flag", timeoutErr, 1);
    chk(csN === 1'b1 && rcN === 1'b1, "R8 strobes released", {csN, rcN}, 3);
    chk(validCnt == v0, "R8 no result", validCnt - v0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    waitCyc(5);
    chk(csN === 1'b1 && rcN === 1'b1, "R1 strobes in reset", {csN, rcN}, 3);
    rstN = 1'b1;
    testReset();
    testSingle();
    testQueued();
    testRead();
    testFreeRun(600);
    testFreeRun(100);
    testOverrun();
    testTimeout();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule